// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns bytes held in a transmit buffer into a serial Ethernet frame, one bit per clock. When the buffer signals that its start threshold has been reached and the channel is free, the builder raises its transmit-enable and sends the preamble and the start delimiter. It then pulls the caller's bytes over a valid/ready stream and serializes them unchanged. It fills short frames with zero bytes when padding is on, and it closes the frame with a CRC-32 check sequence when the check sequence is enabled for that packet.

Padding and check-sequence insertion are chosen per packet. Both control inputs are captured together with the first payload byte, so the caller can prepare the next packet's settings while the current one is still on the line. Field order and content (addresses, length/type, data) are the caller's business. The builder never inspects or reorders them.

Top module: `eth_tx_framer`

## Requirements
- R1: While idle, a frame starts only when `buf_ready` and `chan_ok` are both high at a clock edge. `tx_en` rises in the following cycle. Otherwise `tx_en` stays low.
- R2: The frame opens with 56 preamble bits alternating 1,0,1,0,…, and the first bit is a 1.
- R3: The 8 bits after the preamble are the start delimiter 1,0,1,0,1,0,1,1 in that order. The first payload bit follows directly.
- R4: With padding enabled, bytes of 00h are appended after the last payload byte until payload plus pad reach 60 bytes (64 bytes once the 4 check bytes are counted). Payloads of 60 bytes or more get no pad.
- R5: With padding disabled, no pad byte is ever appended, whatever the payload length.
- R6: Each payload byte is taken through one `in_valid`/`in_ready` transfer, in stream order, and is sent least significant bit first, unchanged. Exactly the bytes up to and including the one marked `in_last` are taken. `in_ready` is high only during a frame, and never in two consecutive cycles.
- R7: With the check sequence enabled, 32 bits follow the data and pad. The CRC uses generator 0x04C11DB7 with the register preset to all ones, covers every payload and pad bit, and the complement of the remainder is sent highest-order coefficient first. In bit terms, bit j of the byte-wise reflected CRC (poly 0xEDB88320, preset all ones, final inversion) is sent as the j-th check bit.
- R8: With the check sequence disabled, the frame ends right after the last payload or pad bit.
- R9: `tx_en` stays high without a gap from the first preamble bit to the last bit of the frame, then drops. A frame therefore lasts 64 + 8·(payload+pad bytes) + 32·(check enabled) cycles.
- R10: `pad_en` and `fcs_en` are sampled in the cycle the first payload byte is taken. Changing them later in the frame has no effect on that frame.
- R11: During and directly after reset, `tx_en`, `tx_bit` and `in_ready` are low, and `tx_bit` is low whenever `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_ready | input | 1 | Transmit buffer has reached its start threshold |
| chan_ok | input | 1 | Channel access currently permitted |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Current byte is the last of the packet |
| in_ready | output | 1 | Builder takes the presented byte at this edge |
| pad_en | input | 1 | Pad short frames (sampled with first byte) |
| fcs_en | input | 1 | Append check sequence (sampled with first byte) |
| tx_en | output | 1 | Frame in progress on the line |
| tx_bit | output | 1 | Serial transmit bit |

## Verification
The main function is swept over every payload length from 1 to 66 bytes with padding and checking both on. This crosses the 60-byte pad boundary from below and above, and exposes any off-by-one in the pad count or the check-sequence window. The three other pad/check combinations are run at lengths chosen around the same boundary (1, 5, 45, 59, 60, 61), which tells unpadded short frames apart from padded ones and frames that end after data from frames that end after the check bytes. Byte contents vary with both position and length, so a swapped bit order, a dropped or repeated byte, or a check computed over the wrong span shows up in a distinct region of the frame. Extra frames toggle the per-packet controls in mid-frame. Idle periods hold one start condition low at a time to confirm that the line stays quiet.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_PAD,
    ST_CHK
  } tx_state_t;

  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

endpackage

// File: rtl/eth_tx_rst_sync.sv
module eth_tx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic crc_init,
  input  logic crc_upd,
  input  logic crc_shift,
  input  logic crc_din,
  output logic crc_msb
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;
  logic             fb;

  // Feedback combines the outgoing top coefficient with the new data bit.
  always_comb begin
    fb     = crc_q[CRC_W-1] ^ crc_din;
    crc_en = crc_init | crc_upd | crc_shift;
    crc_d  = crc_q;
    if (crc_init) begin
      crc_d = '1;
    end else if (crc_upd) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end else if (crc_shift) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_msb = crc_q[CRC_W-1];

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int HDR_BITS   = 64,
  parameter int PAD_TARGET = 60,
  parameter int CNT_W      = 6,
  parameter int BYTE_CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       buf_ready,
  input  logic       chan_ok,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       pad_en,
  input  logic       fcs_en,
  input  logic       crc_msb,
  output logic       in_ready,
  output logic       tx_en,
  output logic       tx_bit,
  output logic       crc_init,
  output logic       crc_upd,
  output logic       crc_shift,
  output logic       crc_din
);

  localparam logic [CNT_W-1:0]      HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0]      BYTE_LAST = CNT_W'(7);
  localparam logic [CNT_W-1:0]      CHK_LAST  = CNT_W'(CRC_W - 1);
  localparam logic [BYTE_CNT_W-1:0] PAD_LIM   = BYTE_CNT_W'(PAD_TARGET);

  tx_state_t             state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [BYTE_CNT_W-1:0] bytes_q, bytes_d;
  logic [7:0]            shreg_q, shreg_d;
  logic                  last_q, last_d;
  logic                  pad_q, pad_d;
  logic                  chk_q, chk_d;
  logic                  take;
  logic [7:0]            in_byte;
  logic [BYTE_CNT_W-1:0] bytes_inc;
  logic                  ctl_en;

  // An underrun byte slot is filled with zero and counted as data.
  assign in_byte   = in_valid ? in_data : 8'h00;
  assign bytes_inc = (bytes_q == PAD_LIM) ? bytes_q : bytes_q + 1'b1;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bytes_d   = bytes_q;
    shreg_d   = shreg_q;
    last_d    = last_q;
    pad_d     = pad_q;
    chk_d     = chk_q;
    take      = 1'b0;
    ctl_en    = 1'b0;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    crc_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (buf_ready && chan_ok) begin
          state_d  = ST_HDR;
          cnt_d    = '0;
          crc_init = 1'b1;
        end
      end
      ST_HDR: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == HDR_LAST) begin
          take    = 1'b1;
          ctl_en  = 1'b1;
          pad_d   = pad_en;
          chk_d   = fcs_en;
          shreg_d = in_byte;
          last_d  = in_valid & in_last;
          bytes_d = BYTE_CNT_W'(1);
          cnt_d   = '0;
          state_d = ST_DATA;
        end
      end
      ST_DATA, ST_PAD: begin
        crc_upd = 1'b1;
        shreg_d = {1'b0, shreg_q[7:1]};
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == BYTE_LAST) begin
          cnt_d = '0;
          if (!last_q) begin
            take    = 1'b1;
            shreg_d = in_byte;
            last_d  = in_valid & in_last;
            bytes_d = bytes_inc;
            state_d = ST_DATA;
          end else if (pad_q && (bytes_q < PAD_LIM)) begin
            shreg_d = 8'h00;
            bytes_d = bytes_inc;
            state_d = ST_PAD;
          end else if (chk_q) begin
            state_d = ST_CHK;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_CHK: begin
        crc_shift = 1'b1;
        cnt_d     = cnt_q + 1'b1;
        if (cnt_q == CHK_LAST) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bytes_q <= '0;
      shreg_q <= '0;
      last_q  <= 1'b0;
      pad_q   <= 1'b1;
      chk_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bytes_q <= bytes_d;
      shreg_q <= shreg_d;
      last_q  <= last_d;
      if (ctl_en) begin
        pad_q <= pad_d;
        chk_q <= chk_d;
      end
    end
  end

  // Output selection
  always_comb begin
    unique case (state_q)
      ST_HDR:          tx_bit = (cnt_q == HDR_LAST) ? 1'b1 : ~cnt_q[0];
      ST_DATA, ST_PAD: tx_bit = shreg_q[0];
      ST_CHK:          tx_bit = ~crc_msb;
      default:         tx_bit = 1'b0;
    endcase
  end

  assign tx_en    = (state_q != ST_IDLE);
  assign in_ready = take;
  assign crc_din  = shreg_q[0];

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int PRE_BYTES = 7,
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       buf_ready,
  input  logic       chan_ok,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       pad_en,
  input  logic       fcs_en,
  output logic       tx_en,
  output logic       tx_bit
);

  localparam int HDR_BITS   = (PRE_BYTES + 1) * 8;
  localparam int PAD_TARGET = MIN_FRAME - FCS_BYTES;
  localparam int CNT_W      = ($clog2(HDR_BITS) > 5) ? $clog2(HDR_BITS) : 5;
  localparam int BYTE_CNT_W = $clog2(PAD_TARGET + 1);

  logic rst_n_s;
  logic crc_init, crc_upd, crc_shift, crc_din, crc_msb;

  eth_tx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  eth_tx_ctrl #(
    .HDR_BITS   (HDR_BITS),
    .PAD_TARGET (PAD_TARGET),
    .CNT_W      (CNT_W),
    .BYTE_CNT_W (BYTE_CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .buf_ready (buf_ready),
    .chan_ok   (chan_ok),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .pad_en    (pad_en),
    .fcs_en    (fcs_en),
    .crc_msb   (crc_msb),
    .in_ready  (in_ready),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .crc_init  (crc_init),
    .crc_upd   (crc_upd),
    .crc_shift (crc_shift),
    .crc_din   (crc_din)
  );

  eth_tx_crc u_crc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .crc_init  (crc_init),
    .crc_upd   (crc_upd),
    .crc_shift (crc_shift),
    .crc_din   (crc_din),
    .crc_msb   (crc_msb)
  );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
  parameter int MIN_BITS = 72
) (
  input logic clk,
  input logic rst_n,
  input logic buf_ready,
  input logic chan_ok,
  input logic in_ready,
  input logic tx_en,
  input logic tx_bit
);

  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (tx_en) begin
      run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 16'd1;
    end else begin
      run_q <= '0;
    end
  end

  assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(buf_ready && chan_ok));

  assert_first_bit_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> tx_bit);

  assert_ready_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en);

  assert_ready_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  assert_burst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (run_q[2:0] == 3'd0 && run_q >= 16'(MIN_BITS)));

  assert_quiet_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_bit);

endmodule

bind eth_tx_framer eth_tx_framer_chk #(
  .MIN_BITS ((PRE_BYTES + 1) * 8 + 8)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_ready (buf_ready),
  .chan_ok   (chan_ok),
  .in_ready  (in_ready),
  .tx_en     (tx_en),
  .tx_bit    (tx_bit)
);

// File: tb/eth_tx_framer_test.sv
`timescale 1ns/1ps
module eth_tx_framer_test;

  logic       clk;
  logic       rst_n;
  logic       buf_ready, chan_ok;
  logic [7:0] in_data;
  logic       in_valid, in_last, in_ready;
  logic       pad_en, fcs_en;
  logic       tx_en, tx_bit;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [7:0] pay  [0:127];
  bit         expb [0:1023];
  bit         gotb [0:1023];
  int         nexp, ngot, ndata;

  eth_tx_framer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_ready (buf_ready),
    .chan_ok   (chan_ok),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .pad_en    (pad_en),
    .fcs_en    (fcs_en),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Expected bit stream from the requirements; CRC in reflected byte form.
  task automatic build_exp(input int len, input bit pad, input bit fcs);
    logic [31:0] crc;
    logic [31:0] f;
    logic [7:0]  b;
    int n;
    n = 0;
    for (int k = 0; k < 56; k++) begin
      expb[n] = (k % 2 == 0);
      n++;
    end
    for (int k = 0; k < 8; k++) begin
      expb[n] = (k % 2 == 0) || (k == 7);
      n++;
    end
    ndata = (pad && len < 60) ? 60 : len;
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < ndata; i++) begin
      b = (i < len) ? pay[i] : 8'h00;
      for (int j = 0; j < 8; j++) begin
        expb[n] = b[j];
        n++;
      end
      crc = crc ^ {24'h0, b};
      for (int j = 0; j < 8; j++) begin
        crc = crc[0] ? ((crc >> 1) ^ 32'hEDB8_8320) : (crc >> 1);
      end
    end
    if (fcs) begin
      f = ~crc;
      for (int j = 0; j < 32; j++) begin
        expb[n] = f[j];
        n++;
      end
    end
    nexp = n;
  endtask

  task automatic cmp_region(input int lo, input int hi, input string req,
                            input string what);
    int mism;
    mism = 0;
    for (int i = lo; i < hi; i++) begin
      if (i >= ngot || gotb[i] != expb[i]) mism++;
    end
    check(mism == 0, req, what, mism, 0);
  endtask

  task automatic run_frame(input int len, input bit pad, input bit fcs,
                           input bit flip);
    int  idx, cycles, lat;
    bit  took, started, done, flipped;
    for (int i = 0; i < len; i++) pay[i] = 8'((i * 37) ^ (len * 11) ^ 8'h5A);
    build_exp(len, pad, fcs);
    @(negedge clk);
    pad_en = pad; fcs_en = fcs;
    buf_ready = 1'b1; chan_ok = 1'b1;
    idx = 0; took = 0; started = 0; done = 0; flipped = 0;
    cycles = 0; lat = -1; ngot = 0;
    in_valid = (len > 0); in_data = pay[0]; in_last = (len == 1);
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
      if (took) idx++;
      in_valid = (idx < len);
      in_data  = (idx < len) ? pay[idx] : 8'h00;
      in_last  = (idx == len - 1);
      if (flip && idx >= 1 && !flipped) begin
        pad_en = ~pad; fcs_en = ~fcs; flipped = 1;
      end
      took = in_ready && in_valid;
      if (tx_en) begin
        if (!started) lat = cycles;
        started = 1;
        buf_ready = 1'b0;
        if (ngot < 1024) gotb[ngot] = tx_bit;
        ngot++;
      end else if (started) begin
        done = 1;
      end
    end
    in_valid = 1'b0; in_last = 1'b0; chan_ok = 1'b0; buf_ready = 1'b0;
    check(done, "R9", "frame completed", int'(done), 1);
    check(lat == 1, "R1", "start latency cycles", lat, 1);
    check(idx == len, "R6", "bytes taken", idx, len);
    check(ngot == nexp, flip ? "R10" : (pad ? "R4" : "R5"), "frame length bits", ngot, nexp);
    cmp_region(0, 56, "R2", "preamble bit mismatches");
    cmp_region(56, 64, "R3", "delimiter bit mismatches");
    cmp_region(64, 64 + 8 * len, "R6", "payload bit mismatches");
    if (ndata > len) cmp_region(64 + 8 * len, 64 + 8 * ndata, "R4", "pad bit mismatches");
    if (fcs) cmp_region(64 + 8 * ndata, nexp, "R7", "check bit mismatches");
    else check(ngot == 64 + 8 * ndata, "R8", "frame ends after data", ngot, 64 + 8 * ndata);
  endtask

  task automatic idle_hold(input bit br, input bit co, input string what);
    int hi;
    hi = 0;
    @(negedge clk);
    buf_ready = br; chan_ok = co;
    repeat (30) begin
      @(negedge clk);
      if (tx_en || in_ready) hi++;
    end
    buf_ready = 1'b0; chan_ok = 1'b0;
    check(hi == 0, "R1", what, hi, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi;
    int lens[6] = '{1, 5, 45, 59, 60, 61};
    rst_n = 1'b0; buf_ready = 1'b0; chan_ok = 1'b0;
    in_data = 8'h00; in_valid = 1'b0; in_last = 1'b0;
    pad_en = 1'b1; fcs_en = 1'b1;
    repeat (3) @(negedge clk);
    check(!tx_en && !tx_bit && !in_ready, "R11", "outputs in reset",
          int'({tx_en, tx_bit, in_ready}), 0);
    rst_n = 1'b1;
    hi = 0;
    repeat (4) begin
      @(negedge clk);
      if (tx_en || tx_bit || in_ready) hi++;
    end
    check(hi == 0, "R11", "outputs after reset", hi, 0);

    idle_hold(1'b0, 1'b1, "no start without threshold");
    idle_hold(1'b1, 1'b0, "no start without channel");

    for (int len = 1; len <= 66; len++) run_frame(len, 1'b1, 1'b1, 1'b0);
    foreach (lens[i]) run_frame(lens[i], 1'b0, 1'b1, 1'b0);
    foreach (lens[i]) run_frame(lens[i], 1'b1, 1'b0, 1'b0);
    foreach (lens[i]) run_frame(lens[i], 1'b0, 1'b0, 1'b0);
    // R10: controls flipped after the first byte must not matter
    run_frame(10, 1'b1, 1'b1, 1'b1);
    run_frame(10, 1'b0, 1'b0, 1'b1);
    run_frame(3, 1'b1, 1'b0, 1'b1);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule